// File: doc/BRIEF.md
# DMA Command Decoder Frontend

This block sits between a processor core and a DMA engine. The core sends it custom instructions, each made of a 32-bit instruction word and two 32-bit operand values. Some instructions only load configuration registers: the 64-bit source and destination addresses, the two row strides and the repeat count. A copy instruction turns the current configuration and its own byte size into a transfer descriptor and returns a fresh transaction identifier. A status instruction reports either how many transfers have finished or whether any transfer is still outstanding.

The core issues with a valid/ready handshake. Every accepted instruction gets exactly one registered response one cycle later. Descriptors leave on a valid/ready port. While a descriptor waits there, the core-side ready stays low. The data mover beneath pulses a completion input once per finished transfer, in issue order. Software waits for transaction `t` by polling the completion count until it exceeds `t`.

Top module: `dma_cmd_frontend`

## Requirements
- R1: An instruction is legal only if bits 6:0 equal 0101011 and bits 14:12 equal 000. Any other word gets a response with the illegal flag set.
- R2: funct7 (bits 31:25) = 0 loads the source address and funct7 = 1 loads the destination address. In both cases bits 31:0 come from operand 1 and bits 63:32 from operand 2.
- R3: funct7 = 6 loads the source stride from operand 1 and the destination stride from operand 2. funct7 = 7 loads the repeat count from operand 1.
- R4: funct7 = 2 (copy) raises the descriptor valid one cycle after acceptance. The descriptor carries the stored addresses and takes its size from operand 1. Bit 21 of the instruction (bit 1 of the immediate in bits 24:20) selects 2D. In 2D mode the descriptor carries the stored strides and repeat count; in 1D mode those three fields are zero.
- R5: Transaction IDs start at 0 after reset and rise by one per accepted copy. The copy response data and the descriptor ID both equal the ID assigned to that copy.
- R6: While the descriptor valid is high, the issue ready is low. Every descriptor field holds steady until the descriptor ready is seen high.
- R7: A status instruction (funct7 = 4) with selector (bits 24:20) 0 returns the completion count. The count rises by one per completion pulse and never exceeds the number of copies issued; a pulse with nothing outstanding is ignored.
- R8: A status instruction with selector 2 returns 1 while issued copies exceed completions and 0 otherwise. Any other selector returns 0.
- R9: funct7 values 3, 5 and 8 to 127 set the illegal flag and change no configuration, ID or count.
- R10: Exactly one cycle after each accepted instruction, the response valid is high for one cycle, with rd equal to bits 11:7. Configuration and illegal instructions return data 0. The response valid is low in every other cycle.
- R11: Configuration values persist across copies until they are rewritten.
- R12: After reset, issue ready is 1, response and descriptor valids are 0, and all configuration, IDs and counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid_i | input | 1 | Core offers an instruction |
| issue_ready_o | output | 1 | Frontend accepts an instruction |
| issue_instr_i | input | 32 | Instruction word |
| issue_rs1_i | input | XLEN | Operand 1 value |
| issue_rs2_i | input | XLEN | Operand 2 value |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rd_o | output | 5 | Destination register index |
| rsp_data_o | output | XLEN | Response value |
| rsp_illegal_o | output | 1 | Instruction was not recognised |
| desc_valid_o | output | 1 | Descriptor available |
| desc_ready_i | input | 1 | Data mover takes the descriptor |
| desc_src_o | output | 2*XLEN | Source address |
| desc_dst_o | output | 2*XLEN | Destination address |
| desc_size_o | output | XLEN | Bytes per row |
| desc_src_stride_o | output | XLEN | Source row stride (0 in 1D) |
| desc_dst_stride_o | output | XLEN | Destination row stride (0 in 1D) |
| desc_reps_o | output | XLEN | Row repeat count (0 in 1D) |
| desc_2d_o | output | 1 | 2D transfer |
| desc_id_o | output | XLEN | Transaction ID |
| done_i | input | 1 | One transfer completed |

## Verification
On every cycle, the assertions check the response timing and the descriptor handshake: the issue stall while a descriptor is pending, the hold of its fields, its appearance after a copy and the ID step. They also check that an illegal word changes no count and that completions never pass issues. The values themselves need the bench's scenarios. These cover address and stride loading, persistence across copies, the zeroing of 2D fields in 1D mode, status results as completions arrive, and proof that an illegal word left the configuration intact, observed through the next descriptor.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  localparam logic [6:0] OPC_DMA = 7'b0101011;
  localparam logic [2:0] F3_DMA  = 3'b000;
  localparam int         SEL_DONE = 0;
  localparam int         SEL_BUSY = 2;
  localparam int         CFG_2D_BIT = 1;

  typedef enum logic [2:0] {
    OP_SRC, OP_DST, OP_COPY, OP_STAT, OP_STRIDE, OP_REPS, OP_BAD
  } op_e;
endpackage

// File: rtl/dma_fe_decode.sv
module dma_fe_decode
  import dma_fe_pkg::*;
(
  input  logic [31:0] instr_i,
  output op_e         op_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  imm_o
);
  logic unused_rs1_field;
  assign unused_rs1_field = ^instr_i[19:15];

  assign rd_o  = instr_i[11:7];
  assign imm_o = instr_i[24:20];

  always_comb begin
    op_o = OP_BAD;
    if (instr_i[6:0] == OPC_DMA && instr_i[14:12] == F3_DMA) begin
      case (instr_i[31:25])
        7'd0:    op_o = OP_SRC;
        7'd1:    op_o = OP_DST;
        7'd2:    op_o = OP_COPY;
        7'd4:    op_o = OP_STAT;
        7'd6:    op_o = OP_STRIDE;
        7'd7:    op_o = OP_REPS;
        default: op_o = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/dma_fe_cfg.sv
module dma_fe_cfg
  import dma_fe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  op_e               op_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  output logic [2*XLEN-1:0] src_o,
  output logic [2*XLEN-1:0] dst_o,
  output logic [XLEN-1:0]   sstride_o,
  output logic [XLEN-1:0]   dstride_o,
  output logic [XLEN-1:0]   reps_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o     <= '0;
      dst_o     <= '0;
      sstride_o <= '0;
      dstride_o <= '0;
      reps_o    <= '0;
    end else if (wr_i) begin
      case (op_i)
        OP_SRC:    src_o <= {rs2_i, rs1_i};
        OP_DST:    dst_o <= {rs2_i, rs1_i};
        OP_STRIDE: begin
          sstride_o <= rs1_i;
          dstride_o <= rs2_i;
        end
        OP_REPS:   reps_o <= rs1_i;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/dma_fe_track.sv
module dma_fe_track #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            copy_i,
  input  logic            done_i,
  output logic [XLEN-1:0] issued_o,
  output logic [XLEN-1:0] completed_o,
  output logic            busy_o
);
  logic outstanding;
  assign outstanding = (issued_o != completed_o);
  assign busy_o      = outstanding;

  always_ff @(posedge clk) begin
    if (rst) begin
      issued_o    <= '0;
      completed_o <= '0;
    end else begin
      if (copy_i) issued_o <= issued_o + 1'b1;
      if (done_i && outstanding) completed_o <= completed_o + 1'b1;
    end
  end
endmodule

// File: rtl/dma_cmd_frontend.sv
module dma_cmd_frontend
  import dma_fe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [31:0]       issue_instr_i,
  input  logic [XLEN-1:0]   issue_rs1_i,
  input  logic [XLEN-1:0]   issue_rs2_i,
  output logic              rsp_valid_o,
  output logic [4:0]        rsp_rd_o,
  output logic [XLEN-1:0]   rsp_data_o,
  output logic              rsp_illegal_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [2*XLEN-1:0] desc_src_o,
  output logic [2*XLEN-1:0] desc_dst_o,
  output logic [XLEN-1:0]   desc_size_o,
  output logic [XLEN-1:0]   desc_src_stride_o,
  output logic [XLEN-1:0]   desc_dst_stride_o,
  output logic [XLEN-1:0]   desc_reps_o,
  output logic              desc_2d_o,
  output logic [XLEN-1:0]   desc_id_o,
  input  logic              done_i
);
  op_e              op;
  logic [4:0]       rd_fld;
  logic [4:0]       imm_fld;
  logic             fire;
  logic             copy_fire;
  logic             sel_2d;
  logic [2*XLEN-1:0] cfg_src, cfg_dst;
  logic [XLEN-1:0]  cfg_sstr, cfg_dstr, cfg_reps;
  logic [XLEN-1:0]  issued_cnt, done_cnt;
  logic             busy;
  logic [XLEN-1:0]  rsp_next;

  dma_fe_decode u_dec (
    .instr_i (issue_instr_i),
    .op_o    (op),
    .rd_o    (rd_fld),
    .imm_o   (imm_fld)
  );

  assign issue_ready_o = ~desc_valid_o;
  assign fire          = issue_valid_i & issue_ready_o;
  assign copy_fire     = fire & (op == OP_COPY);
  assign sel_2d        = imm_fld[CFG_2D_BIT];

  dma_fe_cfg #(.XLEN(XLEN)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (fire),
    .op_i      (op),
    .rs1_i     (issue_rs1_i),
    .rs2_i     (issue_rs2_i),
    .src_o     (cfg_src),
    .dst_o     (cfg_dst),
    .sstride_o (cfg_sstr),
    .dstride_o (cfg_dstr),
    .reps_o    (cfg_reps)
  );

  dma_fe_track #(.XLEN(XLEN)) u_trk (
    .clk         (clk),
    .rst         (rst),
    .copy_i      (copy_fire),
    .done_i      (done_i),
    .issued_o    (issued_cnt),
    .completed_o (done_cnt),
    .busy_o      (busy)
  );

  always_comb begin
    rsp_next = '0;
    case (op)
      OP_COPY: rsp_next = issued_cnt;
      OP_STAT: begin
        if (imm_fld == 5'(SEL_DONE))      rsp_next = done_cnt;
        else if (imm_fld == 5'(SEL_BUSY)) rsp_next = XLEN'(busy);
      end
      default: rsp_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o   <= 1'b0;
      rsp_rd_o      <= '0;
      rsp_data_o    <= '0;
      rsp_illegal_o <= 1'b0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_rd_o      <= rd_fld;
        rsp_data_o    <= rsp_next;
        rsp_illegal_o <= (op == OP_BAD);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_valid_o      <= 1'b0;
      desc_src_o        <= '0;
      desc_dst_o        <= '0;
      desc_size_o       <= '0;
      desc_src_stride_o <= '0;
      desc_dst_stride_o <= '0;
      desc_reps_o       <= '0;
      desc_2d_o         <= 1'b0;
      desc_id_o         <= '0;
    end else if (copy_fire) begin
      desc_valid_o      <= 1'b1;
      desc_src_o        <= cfg_src;
      desc_dst_o        <= cfg_dst;
      desc_size_o       <= issue_rs1_i;
      desc_src_stride_o <= sel_2d ? cfg_sstr : '0;
      desc_dst_stride_o <= sel_2d ? cfg_dstr : '0;
      desc_reps_o       <= sel_2d ? cfg_reps : '0;
      desc_2d_o         <= sel_2d;
      desc_id_o         <= issued_cnt;
    end else if (desc_ready_i) begin
      desc_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_fe_checker.sv
module dma_fe_checker #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid_i,
  input logic              issue_ready_o,
  input logic [31:0]       issue_instr_i,
  input logic [XLEN-1:0]   issue_rs1_i,
  input logic              rsp_valid_o,
  input logic              rsp_illegal_o,
  input logic              desc_valid_o,
  input logic              desc_ready_i,
  input logic [2*XLEN-1:0] desc_src_o,
  input logic [2*XLEN-1:0] desc_dst_o,
  input logic [XLEN-1:0]   desc_size_o,
  input logic [XLEN-1:0]   desc_id_o,
  input logic [XLEN-1:0]   cnt_issued,
  input logic [XLEN-1:0]   cnt_done
);
  logic acc, base_ok, is_copy, is_bad;
  assign acc     = issue_valid_i && issue_ready_o;
  assign base_ok = (issue_instr_i[6:0] == 7'b0101011) && (issue_instr_i[14:12] == 3'b000);
  assign is_copy = base_ok && (issue_instr_i[31:25] == 7'd2);
  assign is_bad  = !base_ok || !(issue_instr_i[31:25] inside {7'd0, 7'd1, 7'd2, 7'd4, 7'd6, 7'd7});

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> !desc_valid_o && !rsp_valid_o && issue_ready_o);

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (rst)
    acc && is_bad |=> rsp_illegal_o && cnt_issued == $past(cnt_issued));

  assert_copy_desc_R4: assert property (@(posedge clk) disable iff (rst)
    acc && is_copy |=> desc_valid_o && desc_size_o == $past(issue_rs1_i));

  assert_id_step_R5: assert property (@(posedge clk) disable iff (rst)
    acc && is_copy |=> desc_id_o == $past(cnt_issued) && cnt_issued == $past(cnt_issued) + 1'b1);

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    desc_valid_o |-> !issue_ready_o);

  assert_desc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_src_o) &&
      $stable(desc_dst_o) && $stable(desc_size_o) && $stable(desc_id_o));

  assert_done_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_done <= cnt_issued);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid_o);

  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid_o);
endmodule

bind dma_cmd_frontend dma_fe_checker #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .issue_valid_i (issue_valid_i),
  .issue_ready_o (issue_ready_o),
  .issue_instr_i (issue_instr_i),
  .issue_rs1_i   (issue_rs1_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_illegal_o (rsp_illegal_o),
  .desc_valid_o  (desc_valid_o),
  .desc_ready_i  (desc_ready_i),
  .desc_src_o    (desc_src_o),
  .desc_dst_o    (desc_dst_o),
  .desc_size_o   (desc_size_o),
  .desc_id_o     (desc_id_o),
  .cnt_issued    (issued_cnt),
  .cnt_done      (done_cnt)
);

// File: tb/dma_cmd_frontend_tb.sv
module dma_cmd_frontend_tb;
  localparam int XLEN = 32;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst = 1'b1;
  logic issue_valid_i = 1'b0, desc_ready_i = 1'b1, done_i = 1'b0;
  logic [31:0] issue_instr_i = '0;
  logic [XLEN-1:0] issue_rs1_i = '0, issue_rs2_i = '0;
  logic issue_ready_o, rsp_valid_o, rsp_illegal_o, desc_valid_o, desc_2d_o;
  logic [4:0] rsp_rd_o;
  logic [XLEN-1:0] rsp_data_o, desc_size_o, desc_src_stride_o, desc_dst_stride_o, desc_reps_o, desc_id_o;
  logic [2*XLEN-1:0] desc_src_o, desc_dst_o;

  always #(TCLK/2) clk = ~clk;

  dma_cmd_frontend #(.XLEN(XLEN)) u_dut (.*);

  int n_vec = 0, n_bad = 0;
  logic [63:0] m_src = '0, m_dst = '0;
  logic [31:0] m_ss = '0, m_ds = '0, m_rep = '0, m_iss = '0, m_done = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] f24, input logic [4:0] rd);
    return {f7, f24, 5'd3, 3'b000, rd, 7'b0101011};
  endfunction

  function automatic bit legal(input logic [31:0] w);
    return w[6:0] == 7'b0101011 && w[14:12] == 3'b000 &&
           (w[31:25] inside {7'd0, 7'd1, 7'd2, 7'd4, 7'd6, 7'd7});
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] w);
    if (!legal(w)) return 0;
    if (w[31:25] == 7'd2) return m_iss;
    if (w[31:25] == 7'd4) begin
      if (w[24:20] == 5'd0) return m_done;
      if (w[24:20] == 5'd2) return (m_iss != m_done) ? 32'd1 : 32'd0;
    end
    return 0;
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b, input int stall);
    logic [31:0] ed;
    bit cp, twod;
    ed   = exp_data(w);
    cp   = legal(w) && w[31:25] == 7'd2;
    twod = w[21];
    while (!issue_ready_o) @(negedge clk);
    desc_ready_i  = (stall == 0);
    issue_valid_i = 1'b1; issue_instr_i = w; issue_rs1_i = a; issue_rs2_i = b;
    @(posedge clk); @(negedge clk);
    issue_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1, "R10 rsp_valid", rsp_valid_o, 1);
    chk(rsp_rd_o == w[11:7], "R10 rd", rsp_rd_o, w[11:7]);
    chk(rsp_illegal_o == !legal(w), "R1/R9 illegal flag", rsp_illegal_o, !legal(w));
    chk(rsp_data_o == ed, "R5/R7/R8 rsp data", rsp_data_o, ed);
    if (cp) begin
      chk(desc_valid_o == 1'b1, "R4 desc valid", desc_valid_o, 1);
      chk(desc_src_o == m_src && desc_dst_o == m_dst, "R2/R11 desc addr", desc_src_o, m_src);
      chk(desc_size_o == a, "R4 size", desc_size_o, a);
      chk(desc_2d_o == twod, "R4 mode", desc_2d_o, twod);
      chk(desc_src_stride_o == (twod ? m_ss : 0) && desc_dst_stride_o == (twod ? m_ds : 0),
          "R3/R4 strides", desc_src_stride_o, twod ? m_ss : 0);
      chk(desc_reps_o == (twod ? m_rep : 0), "R3/R4 reps", desc_reps_o, twod ? m_rep : 0);
      chk(desc_id_o == m_iss, "R5 desc id", desc_id_o, m_iss);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(issue_ready_o == 1'b0 && desc_valid_o == 1'b1 && desc_size_o == a,
            "R6 stall hold", {issue_ready_o, desc_valid_o}, 2'b01);
      end
      desc_ready_i = 1'b1;
      @(negedge clk);
      chk(desc_valid_o == 1'b0 && issue_ready_o == 1'b1, "R6 release", desc_valid_o, 0);
      m_iss++;
    end else if (legal(w)) begin
      case (w[31:25])
        7'd0: m_src = {b, a};
        7'd1: m_dst = {b, a};
        7'd6: begin m_ss = a; m_ds = b; end
        7'd7: m_rep = a;
        default: ;
      endcase
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
    if (m_done != m_iss) m_done++;
    chk(rsp_valid_o == 1'b0, "R10 no spurious rsp", rsp_valid_o, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(issue_ready_o && !rsp_valid_o && !desc_valid_o, "R12 reset idle",
        {issue_ready_o, rsp_valid_o, desc_valid_o}, 3'b100);
    send(mk(7'd4, 5'd0, 5'd5), 0, 0, 0);   // R12 R7 count zero
    send(mk(7'd4, 5'd2, 5'd5), 0, 0, 0);   // R8 idle
    pulse_done();                           // R7 ignored with nothing outstanding
    send(mk(7'd4, 5'd0, 5'd6), 0, 0, 0);
    send(mk(7'd2, 5'd0, 5'd10), 32'd64, 0, 0); // R12 config zero, first id 0
    send(mk(7'd0, 5'd0, 5'd0), 32'h1000_0000, 32'h0000_0001, 0); // R2
    send(mk(7'd1, 5'd0, 5'd0), 32'h2000_0040, 32'h0000_0002, 0);
    send(mk(7'd6, 5'd0, 5'd0), 32'd256, 32'd512, 0);             // R3
    send(mk(7'd7, 5'd0, 5'd0), 32'd9, 0, 0);
    send(mk(7'd2, 5'd2, 5'd11), 32'd128, 0, 3);   // R4 2D, R6 stall
    send(mk(7'd2, 5'd0, 5'd12), 32'd32, 0, 1);    // R11 reuse, 1D zeros
    send(mk(7'd3, 5'd0, 5'd1), 32'hdead, 32'hbeef, 0);        // R9
    send(mk(7'd5, 5'd2, 5'd1), 32'hdead, 32'hbeef, 0);        // R9
    send(mk(7'd0, 5'd0, 5'd2) ^ 32'h0000_1000, 32'h5, 32'h6, 0); // R1 funct3
    send(mk(7'd0, 5'd0, 5'd2) ^ 32'h0000_0001, 32'h5, 32'h6, 0); // R1 opcode
    send(mk(7'd2, 5'd2, 5'd13), 32'd16, 0, 0);    // R9 config untouched
    send(mk(7'd4, 5'd2, 5'd7), 0, 0, 0);          // R8 busy
    send(mk(7'd4, 5'd5, 5'd7), 0, 0, 0);          // R8 other selector
    pulse_done();
    send(mk(7'd4, 5'd0, 5'd8), 0, 0, 0);          // R7
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [6:0] f7;
      r = int'($urandom % 9);
      case (r)
        0: f7 = 7'd0; 1: f7 = 7'd1; 2: f7 = 7'd6; 3: f7 = 7'd7;
        4, 5: f7 = 7'd2; 6: f7 = 7'd4;
        7: f7 = ($urandom % 2) ? 7'd3 : 7'(8 + $urandom % 120);
        default: f7 = 7'd0;
      endcase
      if (r == 8) pulse_done();
      else send(mk(f7, 5'($urandom), 5'($urandom)), $urandom, $urandom, int'($urandom % 3));
    end
    while (m_done != m_iss) pulse_done();
    send(mk(7'd4, 5'd2, 5'd9), 0, 0, 0);          // R8 drained
    send(mk(7'd4, 5'd0, 5'd9), 0, 0, 0);          // R7 final count
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule